// File: doc/BRIEF.md
# Conversion Pacing and Hold Controller

This block paces a dual-slope conversion sequencer by driving its clock enable. The sequencer emits a one-cycle pulse as it enters its zero phase. At that point the controller decides whether the next conversion may begin at once, after a programmable pause, or only after an operator command. The pause length stands in for a display-rate knob. A separate select skips the pause so that conversions run back to back.

Two asynchronous commands act on the controller, and both are active low. The hold level lets the conversion already in progress finish and store its result. It then freezes the sequencer at the next zero phase and keeps it frozen until the level is released. The trigger input releases a frozen sequencer for exactly one conversion, after which it freezes again at the next zero phase. The sequencer only ever stops at the start of a zero phase and never in the middle of a reading.

Top module: `conv_pace_ctl`

## Requirements
- R1: After reset, `seq_en` is high, so the first conversion starts with no pause.
- R2: With `rate_max` low and hold inactive, a `zero_start` pulse sampled at a clock edge drives `seq_en` low from that edge. `seq_en` then stays low for exactly `pause_len`+1 cycles and returns high (a value of 0 gives a one-cycle gap).
- R3: With `rate_max` high and hold inactive, `seq_en` stays high through a `zero_start` pulse.
- R4: `pause_len` is captured on the `zero_start` pulse, so a change during a pause does not alter that pause.
- R5: Asserting `hold_n` (low) does not lower `seq_en` during a running conversion. At the next `zero_start`, `seq_en` falls and stays low while hold remains asserted and no trigger arrives, whatever the value of `rate_max`.
- R6: When `hold_n` is released (high) while the sequencer is frozen, `seq_en` rises on the third clock edge after the release.
- R7: A falling edge on `trig_n` while frozen raises `seq_en` on the third clock edge after the fall. `seq_en` stays high until the next `zero_start`, where it falls again if hold is still asserted.
- R8: A `trig_n` falling edge during a running conversion or during a pause has no effect: the pause length is unchanged, and the edge is not remembered for a later hold.
- R9: If hold becomes asserted during a pause, `seq_en` stays low when the pause ends, until hold is released or a trigger arrives.
- R10: Holding `trig_n` low releases only one conversion. Only a new falling edge can release another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zero_start | input | 1 | One-cycle pulse from the sequencer at the start of its zero phase |
| rate_max | input | 1 | High selects back-to-back conversions with no pause |
| pause_len | input | PAUSE_W | Pause length in cycles, minus one |
| hold_n | input | 1 | Asynchronous active-low hold level |
| trig_n | input | 1 | Asynchronous active-low single-conversion trigger |
| seq_en | output | 1 | Clock enable for the sequencer |

## Verification
The bench measures the exact length of the gap for pause values of zero, a middle value and the maximum. An off-by-one timer would show up as a gap one cycle too long or too short. It changes `pause_len` in the middle of a pause, which catches a design that reads the value live instead of capturing it. It fires triggers while running and while pausing, then applies hold: a design that latched those edges would wrongly release the frozen sequencer. It also holds the trigger low across a full conversion to expose a level-sensitive trigger, which would never freeze again. Finally, it asserts hold in the middle of a pause, where a design that checked hold only at `zero_start` would resume when the pause ends.

// File: rtl/conv_pace_pkg.sv
package conv_pace_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_PAUSE = 2'd1,
      ST_HELD  = 2'd2
   } pace_state_e;

endpackage

// File: rtl/cp_sync.sv
// Multi-stage synchronizer for one asynchronous bit.
module cp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [LAST:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[LAST-1:0], d};
   end

   assign q = chain[LAST];
endmodule

// File: rtl/cp_edge.sv
// Converts a synchronized level to a one-cycle pulse on assertion.
module cp_edge #(
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic pulse
);
   logic active;
   logic active_d;

   generate
      if (ACTIVE_LOW) begin : g_low
         assign active = ~lvl;
      end else begin : g_high
         assign active = lvl;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_d <= 1'b0;
      else        active_d <= active;
   end

   assign pulse = active & ~active_d;

   // R10: a steady level never produces two pulses in a row
   p_one_shot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
endmodule

// File: rtl/cp_pause_timer.sv
// Loadable down-counter; expire is high in the last cycle of the interval.
module cp_pause_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] load,
   output logic         busy,
   output logic         expire
);
   generate
      if (W < 1) begin : g_bad_width
         $error("cp_pause_timer: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= load;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   assign expire = busy && (cnt == '0);

   // R4: the interval is captured at start
   p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy && (cnt == $past(load)));

   // R2: each cycle of the interval removes exactly one count
   p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !expire && !start) |=> busy && (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/conv_pace_ctl.sv
// Clock-enable controller that paces, holds and single-steps a conversion sequencer.
module conv_pace_ctl
   import conv_pace_pkg::*;
#(
   parameter int PAUSE_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               zero_start,
   input  logic               rate_max,
   input  logic [PAUSE_W-1:0] pause_len,
   input  logic               hold_n,
   input  logic               trig_n,
   output logic               seq_en
);
   generate
      if (PAUSE_W < 1) begin : g_bad_pause_w
         $error("conv_pace_ctl: PAUSE_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("conv_pace_ctl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic        hold_sync;
   logic        hold_act;
   logic        trig_sync;
   logic        trig_pulse;
   logic        tmr_start;
   logic        tmr_busy;
   logic        tmr_expire;
   pace_state_e state_q;
   pace_state_e state_d;

   cp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hold_sync (
      .clk(clk), .rst_n(rst_n), .d(hold_n), .q(hold_sync));

   cp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_trig_sync (
      .clk(clk), .rst_n(rst_n), .d(trig_n), .q(trig_sync));

   cp_edge #(.ACTIVE_LOW(1'b1)) u_trig_edge (
      .clk(clk), .rst_n(rst_n), .lvl(trig_sync), .pulse(trig_pulse));

   assign hold_act  = ~hold_sync;
   assign tmr_start = (state_q == ST_RUN) && zero_start && !hold_act && !rate_max;

   cp_pause_timer #(.W(PAUSE_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(tmr_start), .load(pause_len),
      .busy(tmr_busy), .expire(tmr_expire));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN: begin
            if (zero_start) begin
               if (hold_act)       state_d = ST_HELD;
               else if (!rate_max) state_d = ST_PAUSE;
            end
         end
         ST_PAUSE: begin
            if (tmr_expire) state_d = hold_act ? ST_HELD : ST_RUN;
         end
         ST_HELD: begin
            if (!hold_act || trig_pulse) state_d = ST_RUN;
         end
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_RUN;
      else        state_q <= state_d;
   end

   assign seq_en = (state_q == ST_RUN);

   // R2: a zero-phase pulse at normal rate closes the enable
   p_pause_on_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_en && zero_start && !rate_max) |=> !seq_en);

   // R2: a pause always runs on the timer
   p_pause_timer_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PAUSE) |-> tmr_busy);

   // R3: back-to-back mode keeps the enable high
   p_back_to_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_en && zero_start && rate_max && !hold_act) |=> seq_en);

   // R5: frozen while hold stays asserted with no trigger
   p_held_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_HELD) && hold_act && !trig_pulse) |=> !seq_en);

   // R6: release of hold restarts the sequencer
   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_HELD) && !hold_act) |=> seq_en);

   // R8: a running conversion is only ended by the zero-phase pulse
   p_trig_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_en && !zero_start) |=> seq_en);

   // R9: hold arriving during a pause freezes at its end
   p_hold_at_expiry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_PAUSE) && tmr_expire && hold_act) |=> (state_q == ST_HELD));
endmodule

// File: tb/tb_conv_pace_ctl.sv
`timescale 1ns/1ps
module tb_conv_pace_ctl;
   localparam int PW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          zero_start = 1'b0;
   logic          rate_max = 1'b0;
   logic [PW-1:0] pause_len = '0;
   logic          hold_n = 1'b1;
   logic          trig_n = 1'b1;
   logic          seq_en;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   conv_pace_ctl #(.PAUSE_W(PW), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .zero_start(zero_start), .rate_max(rate_max),
      .pause_len(pause_len), .hold_n(hold_n), .trig_n(trig_n), .seq_en(seq_en));

   task automatic check(input bit ok, input string req, input int act, input int exp_v);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_zero();
      @(negedge clk);
      zero_start = 1'b1;
      @(negedge clk);
      zero_start = 1'b0;
   endtask

   task automatic measure_low(output int n);
      n = 0;
      while (!seq_en && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   // Returns the number of sampled cycles where seq_en differs from want
   task automatic watch(input int n, input logic want, output int bad);
      bad = 0;
      for (int i = 0; i < n; i++) begin
         if (seq_en !== want) bad++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(seq_en === 1'b1, "R1 enable after reset", seq_en, 1);
      cycles(5);
      check(seq_en === 1'b1, "R1 no initial pause", seq_en, 1);
   endtask

   task automatic t_pause();
      int n;
      pause_len = 8'd5;
      pulse_zero();
      measure_low(n);
      check(n == 6, "R2 pause of 5", n, 6);
      pause_len = 8'd0;
      pulse_zero();
      measure_low(n);
      check(n == 1, "R2 pause of 0", n, 1);
      pause_len = 8'd255;
      pulse_zero();
      measure_low(n);
      check(n == 256, "R2 pause of max", n, 256);
   endtask

   task automatic t_max_rate();
      int bad;
      rate_max = 1'b1;
      pause_len = 8'd40;
      pulse_zero();
      watch(10, 1'b1, bad);
      check(bad == 0, "R3 back to back", bad, 0);
      pulse_zero();
      check(seq_en === 1'b1, "R3 second pulse", seq_en, 1);
      rate_max = 1'b0;
   endtask

   task automatic t_capture();
      int n;
      pause_len = 8'd10;
      pulse_zero();
      pause_len = 8'd2;
      measure_low(n);
      check(n == 11, "R4 captured length", n, 11);
      pulse_zero();
      measure_low(n);
      check(n == 3, "R4 new length next pause", n, 3);
   endtask

   task automatic t_hold_trigger();
      int bad;
      pause_len = 8'd3;
      @(negedge clk);
      hold_n = 1'b0;
      cycles(4);
      check(seq_en === 1'b1, "R5 conversion not interrupted", seq_en, 1);
      pulse_zero();
      watch(20, 1'b0, bad);
      check(bad == 0, "R5 frozen under hold", bad, 0);
      trig_n = 1'b0;
      cycles(2);
      check(seq_en === 1'b0, "R7 trigger latency lower bound", seq_en, 0);
      cycles(1);
      check(seq_en === 1'b1, "R7 trigger releases", seq_en, 1);
      watch(10, 1'b1, bad);
      check(bad == 0, "R7 stays running", bad, 0);
      pulse_zero();
      check(seq_en === 1'b0, "R7 refreezes", seq_en, 0);
      watch(10, 1'b0, bad);
      check(bad == 0, "R10 level trigger one conversion", bad, 0);
      trig_n = 1'b1;
      watch(6, 1'b0, bad);
      check(bad == 0, "R10 trigger release no effect", bad, 0);
      hold_n = 1'b1;
      cycles(2);
      check(seq_en === 1'b0, "R6 release latency lower bound", seq_en, 0);
      cycles(1);
      check(seq_en === 1'b1, "R6 release restarts", seq_en, 1);
   endtask

   task automatic t_hold_max_rate();
      int bad;
      rate_max = 1'b1;
      hold_n = 1'b0;
      cycles(4);
      pulse_zero();
      watch(8, 1'b0, bad);
      check(bad == 0, "R5 hold beats max rate", bad, 0);
      hold_n = 1'b1;
      cycles(3);
      check(seq_en === 1'b1, "R6 release at max rate", seq_en, 1);
      rate_max = 1'b0;
   endtask

   task automatic t_trig_ignored();
      int n;
      int bad;
      trig_n = 1'b0;
      cycles(5);
      trig_n = 1'b1;
      cycles(5);
      check(seq_en === 1'b1, "R8 trigger while running", seq_en, 1);
      pause_len = 8'd20;
      pulse_zero();
      trig_n = 1'b0;
      measure_low(n);
      check(n == 21, "R8 trigger during pause", n, 21);
      trig_n = 1'b1;
      cycles(4);
      hold_n = 1'b0;
      cycles(4);
      pulse_zero();
      watch(12, 1'b0, bad);
      check(bad == 0, "R8 earlier edges not remembered", bad, 0);
      hold_n = 1'b1;
      cycles(4);
   endtask

   task automatic t_hold_in_pause();
      int bad;
      pause_len = 8'd20;
      pulse_zero();
      hold_n = 1'b0;
      watch(35, 1'b0, bad);
      check(bad == 0, "R9 hold during pause", bad, 0);
      hold_n = 1'b1;
      cycles(3);
      check(seq_en === 1'b1, "R9 release after pause hold", seq_en, 1);
   endtask

   initial begin
      cycles(3);
      rst_n = 1'b1;
      t_reset();
      t_pause();
      t_max_rate();
      t_capture();
      t_hold_trigger();
      t_hold_max_rate();
      t_trig_ignored();
      t_hold_in_pause();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 100000; i++) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule